// File: doc/BRIEF.md
# Frequency Lock Monitor with Loss-of-Lock Hysteresis

This block judges whether a recovered serial clock runs at the frequency that a local reference implies, and drives an active-high loss-of-lock flag. The recovered clock first passes through a fixed divide-by-128. The divided edges are counted in the recovered-clock domain. The reference clock, already prescaled to its nominal rate (19.44 MHz in the target system), sets fixed measurement windows of `WIN_CYC` cycles. When the loop is locked, each window holds `WIN_CYC` divided edges.

At every window boundary the reference side toggles a request. The recovered side answers by freezing a Gray-coded copy of its edge count and toggling an acknowledge. The reference side decodes the copy and subtracts the previous one. It then rules the window good or bad against the tolerance `TOL`. A bad window raises the flag at once. The flag drops only after `HYST_WIN` good windows in a row, so a brief return of valid data does not clear it. If the recovered clock stops, a request that is still unanswered at the next boundary also counts as a bad window. Analog loop parts are outside this block.

Top module: `freq_lock_mon`

## Requirements
- R1: While `rst_n` is low and after it rises, `lol` is 1, and it stays 1 until a full hysteresis run of good windows has been measured.
- R2: The recovered clock is divided by exactly 128. Its count is carried to the reference side only as a frozen Gray-coded snapshot under a toggle request/acknowledge. With the divided rate equal to the reference rate, the windows are judged good and `lol` falls to 0.
- R3: A window is bad when the snapshot difference, taken modulo 2^CNT_W, differs from `WIN_CYC` by more than `TOL`. An offset whose count error stays within `TOL` keeps `lol` at 0.
- R4: A single bad verdict sets `lol` to 1 on the next reference edge. This holds whether the recovered clock is too slow or too fast.
- R5: `lol` falls only on the verdict that completes `HYST_WIN` consecutive good windows. It stays 1 for fewer good windows.
- R6: A bad window restarts the good-window run from zero. Good windows seen before it do not count toward clearing `lol`.
- R7: If a request is still unanswered when the next window ends, that window counts as bad. No new request is issued, so a stopped recovered clock sets `lol`.
- R8: After such a stall, the late acknowledge is discarded, and the next snapshot only serves as a new starting point. `lol` clears only after `HYST_WIN` good windows measured after that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk | input | 1 | Recovered clock at the full line rate |
| ref_clk | input | 1 | Prescaled reference clock; all verdicts and `lol` are in this domain |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| lol | output | 1 | Loss-of-lock flag, active high, registered on `ref_clk` |

## Verification
The assertions assume that `rst_n` stays low for at least a few edges of both clocks, so that both domains start from their reset state together. They also assume that the request/acknowledge round trip, a few cycles of each clock, is much shorter than one window. The bench holds reset for many reference cycles. It uses a window of 16 reference cycles, far longer than the handshake, and changes the recovered clock period only between whole half-periods. Each frequency offset is chosen so that the count error lands clearly inside or clearly outside the tolerance, even with one count of quantisation.

// File: rtl/flm_pkg.sv
// Package: shared constants and types for the frequency lock monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package flm_pkg;

    // Fixed divider applied to the recovered clock before counting (2^7 = 128).
    localparam int unsigned REC_DIV_BITS = 7;

    // One window verdict passed from the comparator to the hysteresis stage.
    typedef struct packed {
        logic valid;   // a verdict is present this cycle
        logic bad;     // the window was out of tolerance (or stalled)
    } verdict_t;

endpackage

// File: rtl/flm_rec_count.sv
// Module: recovered-clock side of the monitor.
// Divides the recovered clock by 128, counts the divided edges, keeps a
// Gray-coded copy of the count, and freezes that copy whenever the
// reference side toggles its request. It then toggles the acknowledge.
// Assumes: the request toggles at most once per handshake round trip.
module flm_rec_count
    import flm_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tog,
    output logic [CNT_W-1:0] snap_gray,
    output logic             ack_tog
);

    logic [REC_DIV_BITS-1:0] div_q;
    logic                    div_tick;
    logic [CNT_W-1:0]        bin_q;
    logic [CNT_W-1:0]        bin_next;
    logic [CNT_W-1:0]        gray_q;
    logic                    req_s1, req_s2, req_s3;
    logic                    req_evt;

    assign div_tick = &div_q;
    assign bin_next = div_tick ? bin_q + CNT_W'(1) : bin_q;
    assign req_evt  = req_s2 ^ req_s3;

    // Fixed divide-by-128 prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + REC_DIV_BITS'(1);
    end

    // Binary count of divided edges plus its registered Gray image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_next;
            gray_q <= bin_next ^ (bin_next >> 1);
        end
    end

    // Two-flop synchroniser for the request toggle, plus an edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_tog;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    // Freeze the Gray count and answer each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_gray <= '0;
            ack_tog   <= 1'b0;
        end else if (req_evt) begin
            snap_gray <= gray_q;
            ack_tog   <= ~ack_tog;
        end
    end

    // R2: consecutive Gray values differ in at most one bit.
    a_r2_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);

    // R2: the snapshot moves only in answer to a synchronised request.
    a_r2_snap_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_gray) |-> $past(req_evt));

endmodule

// File: rtl/flm_window_cmp.sv
// Module: reference-side window timer and count comparator.
// Issues a request toggle at each window end, collects the returned
// snapshot, and decodes it from Gray. It then rules each window good or
// bad against the expected count. An unanswered request at a window end
// is a stall: it yields a bad verdict, and the late answer is discarded.
// Assumes: the handshake round trip is far shorter than one window.
module flm_window_cmp
    import flm_pkg::*;
#(
    parameter int unsigned WIN_CYC = 1024,
    parameter int unsigned TOL     = 1,
    parameter int unsigned CNT_W   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] snap_gray,
    input  logic             ack_tog,
    output logic             req_tog,
    output verdict_t         verdict
);

    localparam int unsigned WIN_W = $clog2(WIN_CYC);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
    localparam logic signed [CNT_W:0] EXP_S = (CNT_W+1)'(WIN_CYC);
    localparam logic signed [CNT_W:0] TOL_S = (CNT_W+1)'(TOL);

    logic [WIN_W-1:0] win_cnt;
    logic             win_end;
    logic             ack_s1, ack_s2, ack_s3;
    logic             ack_evt;
    logic             pending;
    logic             primed;
    logic             stale;
    logic [CNT_W-1:0] cur_bin;
    logic [CNT_W-1:0] prev_bin;
    logic [CNT_W-1:0] delta;
    logic signed [CNT_W:0] err;
    logic             out_tol;

    assign win_end = (win_cnt == WIN_LAST);
    assign ack_evt = ack_s2 ^ ack_s3;

    // Gray-to-binary decode of the frozen snapshot.
    always_comb begin
        cur_bin[CNT_W-1] = snap_gray[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            cur_bin[i] = cur_bin[i+1] ^ snap_gray[i];
        end
    end

    // Count difference against the expected number of divided edges.
    always_comb begin
        delta   = cur_bin - prev_bin;
        err     = $signed({1'b0, delta}) - EXP_S;
        out_tol = (err > TOL_S) || (err < -TOL_S);
    end

    // Free-running window timer.
    always_ff @(posedge clk) begin
        if (!rst_n)       win_cnt <= '0;
        else if (win_end) win_cnt <= '0;
        else              win_cnt <= win_cnt + WIN_W'(1);
    end

    // Two-flop synchroniser for the acknowledge toggle, plus an edge stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
            ack_s3 <= 1'b0;
        end else begin
            ack_s1 <= ack_tog;
            ack_s2 <= ack_s1;
            ack_s3 <= ack_s2;
        end
    end

    // Handshake control, stall detection and verdict generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tog  <= 1'b0;
            pending  <= 1'b0;
            primed   <= 1'b0;
            stale    <= 1'b0;
            prev_bin <= '0;
            verdict  <= '0;
        end else begin
            verdict <= '0;
            if (win_end) begin
                if (pending && !ack_evt) begin
                    verdict <= '{valid: 1'b1, bad: 1'b1};
                    primed  <= 1'b0;
                    stale   <= 1'b1;
                end else begin
                    req_tog <= ~req_tog;
                end
            end
            if (ack_evt) begin
                pending <= win_end;
                if (stale) begin
                    stale <= 1'b0;
                end else begin
                    prev_bin <= cur_bin;
                    primed   <= 1'b1;
                    if (primed) begin
                        verdict <= '{valid: 1'b1, bad: out_tol};
                    end
                end
            end else if (win_end && !pending) begin
                pending <= 1'b1;
            end
        end
    end

    // R3: a request is issued only on the last cycle of a window.
    a_r3_req_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_tog) |-> $past(win_end));

    // R7: an unanswered request at a window end yields a bad verdict.
    a_r7_stall_is_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && pending && !ack_evt) |=> (verdict.valid && verdict.bad));

    // R7: no second request while one is outstanding.
    a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack_evt) |=> $stable(req_tog));

endmodule

// File: rtl/flm_hyst.sv
// Module: loss-of-lock flag with asymmetric hysteresis.
// A bad verdict sets the flag and empties the good-run counter. The flag
// clears on the verdict that completes HYST_WIN good windows in a row.
// Assumes: verdicts are single-cycle pulses in the reference domain.
module flm_hyst
    import flm_pkg::*;
#(
    parameter int unsigned HYST_WIN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  verdict_t verdict,
    output logic     lol
);

    localparam int unsigned GOOD_W = $clog2(HYST_WIN + 1);
    localparam logic [GOOD_W-1:0] GOOD_FULL = GOOD_W'(HYST_WIN);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(HYST_WIN - 1);

    logic [GOOD_W-1:0] good_q;

    // Good-run counter and flag update on each verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lol    <= 1'b1;
            good_q <= '0;
        end else if (verdict.valid) begin
            if (verdict.bad) begin
                lol    <= 1'b1;
                good_q <= '0;
            end else begin
                if (good_q < GOOD_FULL) good_q <= good_q + GOOD_W'(1);
                if (good_q >= GOOD_LAST) lol <= 1'b0;
            end
        end
    end

    // R4: any bad verdict leaves the flag set on the next edge.
    a_r4_bad_sets_lol: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict.valid && verdict.bad) |=> lol);

    // R5: the flag falls only on a good verdict completing a full run.
    a_r5_clear_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lol) |-> ($past(verdict.valid && !verdict.bad) && ($past(good_q) == GOOD_LAST)));

    // R6: the run counter never passes its saturation value.
    a_r6_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        good_q <= GOOD_FULL);

endmodule

// File: rtl/freq_lock_mon.sv
// Module: top of the frequency lock monitor.
// Joins the recovered-side counter, the reference-side comparator and
// the hysteresis flag. Only the frozen Gray snapshot and two toggles
// cross between the clock domains.
// Assumes: rst_n is held low for several edges of both clocks.
module freq_lock_mon
    import flm_pkg::*;
#(
    parameter int unsigned WIN_CYC  = 1024,
    parameter int unsigned TOL      = 1,
    parameter int unsigned HYST_WIN = 3
) (
    input  logic rec_clk,
    input  logic ref_clk,
    input  logic rst_n,
    output logic lol
);

    localparam int unsigned CNT_W = $clog2(WIN_CYC) + 3;

    logic             req_tog;
    logic             ack_tog;
    logic [CNT_W-1:0] snap_gray;
    verdict_t         verdict;

    flm_rec_count #(.CNT_W(CNT_W)) u_rec (
        .clk       (rec_clk),
        .rst_n     (rst_n),
        .req_tog   (req_tog),
        .snap_gray (snap_gray),
        .ack_tog   (ack_tog)
    );

    flm_window_cmp #(.WIN_CYC(WIN_CYC), .TOL(TOL), .CNT_W(CNT_W)) u_win (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .snap_gray (snap_gray),
        .ack_tog   (ack_tog),
        .req_tog   (req_tog),
        .verdict   (verdict)
    );

    flm_hyst #(.HYST_WIN(HYST_WIN)) u_hyst (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .verdict (verdict),
        .lol     (lol)
    );

endmodule

// File: tb/freq_lock_mon_tb.sv
`timescale 1ns/1ps
module freq_lock_mon_tb;

    localparam realtime REF_PERIOD = 256.0;   // reference clock period, ns
    localparam realtime REC_NOM    = 2.0;     // nominal recovered period (REF/128)
    localparam int      WIN        = 16;
    localparam int      HYST       = 6;

    logic rec_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic lol;

    realtime rec_per = REC_NOM;
    bit      rec_run = 1'b1;
    int      n_checks = 0;
    int      n_fail   = 0;
    bit      done     = 1'b0;

    freq_lock_mon #(.WIN_CYC(WIN), .TOL(2), .HYST_WIN(HYST)) u_dut (
        .rec_clk (rec_clk),
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .lol     (lol)
    );

    always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;

    initial begin
        forever begin
            #(rec_per / 2.0);
            if (rec_run) rec_clk = ~rec_clk;
        end
    end

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (lol !== exp) begin
            n_fail++;
            $display("FAIL %s: lol=%0b expected %0b at %0t", req, lol, exp, $time);
        end
    endtask

    task automatic wait_win(input int n);
        repeat (n * WIN) @(negedge ref_clk);
    endtask

    task automatic t_reset_and_lock();
        rst_n = 1'b0;
        repeat (8) @(negedge ref_clk);
        check(1'b1, "R1 in reset");
        rst_n = 1'b1;
        @(negedge ref_clk);
        check(1'b1, "R1 just after reset");
        wait_win(HYST - 1);
        check(1'b1, "R1 before full run");
        wait_win(5);
        check(1'b0, "R2 nominal ratio locks");
    endtask

    task automatic t_small_offset();
        rec_per = 2.04;
        wait_win(6);
        check(1'b0, "R3 in-tolerance offset stays locked");
        rec_per = REC_NOM;
        wait_win(2);
        check(1'b0, "R3 back to nominal");
    endtask

    task automatic t_slow_then_restore();
        rec_per = 3.0;
        wait_win(3);
        check(1'b1, "R4 slow clock sets lol");
        rec_per = REC_NOM;
        wait_win(HYST - 1);
        check(1'b1, "R5 held during hysteresis");
        wait_win(5);
        check(1'b0, "R5 clears after run");
    endtask

    task automatic t_fast();
        rec_per = 1.5;
        wait_win(3);
        check(1'b1, "R4 fast clock sets lol");
        rec_per = REC_NOM;
        wait_win(HYST + 4);
        check(1'b0, "R5 clears after fast episode");
    endtask

    task automatic t_run_restart();
        rec_per = 3.0;
        wait_win(2);
        rec_per = REC_NOM;
        wait_win(5);
        check(1'b1, "R6 partial run not yet clear");
        rec_per = 3.0;
        wait_win(2);
        rec_per = REC_NOM;
        wait_win(4);
        check(1'b1, "R6 earlier good windows discarded");
        wait_win(6);
        check(1'b0, "R6 clears after fresh run");
    endtask

    task automatic t_stall();
        rec_run = 1'b0;
        wait_win(3);
        check(1'b1, "R7 stopped clock sets lol");
        wait_win(2);
        check(1'b1, "R7 stays set while stopped");
        rec_run = 1'b1;
        wait_win(HYST);
        check(1'b1, "R8 resync window not counted");
        wait_win(4);
        check(1'b0, "R8 clears after resync and run");
    endtask

    initial begin
        t_reset_and_lock();
        t_small_offset();
        t_slow_then_restore();
        t_fast();
        t_run_restart();
        t_stall();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3000) @(negedge ref_clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule